// File: doc/BRIEF.md
# Three-Mode Timer Unit

This block holds three counters that each follow a different fixed rule and share one start byte. Counter 0 advances on every clock and returns to zero once it has matched its compare value. Counter 1 advances on a millisecond tick and keeps going past its compare value without returning to zero. Counter 2 counts down on every clock and reloads from its compare value after reaching zero. Each counter raises an interrupt request line for one cycle on its event. The three lines feed an interrupt controller that sits outside this block.

The millisecond tick comes from a prescaler that divides the system clock by the parameter `TICK_DIV`. The default of 100000 gives 1 ms at 100 MHz. Software can read this divisor from a read-only register. The prescaler runs only while counter 1 is started, and it starts again from zero each time counter 1 is started.

All registers sit behind a single-cycle word address/data port. Writes take effect at the clock edge. Reads are combinational.

Top module: `tri_timer`

## Requirements
- R1: After reset the start bits, every compare register and every counter read 0, and all interrupt lines are low.
- R2: The register map uses word addresses. Address 0 is the start byte and address 1 is the divisor. Addresses 2, 3 and 4 are compare 0, 1 and 2. Addresses 5, 6 and 7 are counters 0, 1 and 2. Address 1 always reads `TICK_DIV`, and a write to it has no effect.
- R3: In the start byte, bit 0 runs counter 0, bit 1 runs counter 1 and bit 2 runs counter 2. While its bit is 0 a counter holds its value. Setting or clearing a bit never resets the count.
- R4: A running counter 0 adds 1 on each clock. When it equals compare 0 at an edge, it becomes 0 and `irq[0]` is high for the following cycle.
- R5: The millisecond tick fires once every `TICK_DIV` clocks while bit 1 is set. The first tick comes `TICK_DIV` clocks after the start takes effect, every time counter 1 is started.
- R6: A running counter 1 adds 1 on each tick. `irq[1]` is high for one cycle after the tick that brings it onto compare 1. Counting then goes on past that value with no further request.
- R7: A running counter 2 subtracts 1 on each clock. At an edge where it is 0, it reloads compare 2 and `irq[2]` is high for the following cycle.
- R8: A write to a counter register replaces the count at that edge. Any step or event the counter would have had in that cycle is suppressed.
- R9: Each request is a single-cycle pulse and falls in the next cycle unless a new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data |
| irq | output | 3 | Request pulses: bit 0 is trap 0x10, bit 1 is trap 0x11, bit 2 is trap 0x12 |

## Verification
A register write lands at the edge that follows the strobe, and a read shows the result in the same cycle. Counters 0 and 2 move once per edge after the start bit is registered, so the bench counts edges from the write that set the bit. A request shows in the cycle after its event edge, alongside the counter's wrapped or reloaded value. Counter 1 moves exactly `TICK_DIV` edges after its start takes effect. The bench drives inputs and samples outputs on the falling edge, and it steps a known number of rising edges before each comparison.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    localparam int ADDR_W  = 3;
    localparam int N_CHAN  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_TICK     = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 3'd5;

    typedef enum logic [1:0] {
        MODE_UP_WRAP     = 2'd0,
        MODE_TICK_UP     = 2'd1,
        MODE_DOWN_RELOAD = 2'd2
    } tmr_mode_e;

    function automatic tmr_mode_e chan_mode(input int idx);
        case (idx)
            0:       return MODE_UP_WRAP;
            1:       return MODE_TICK_UP;
            default: return MODE_DOWN_RELOAD;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
        return A_CMP_BASE + ADDR_W'(idx);
    endfunction

    function automatic logic [ADDR_W-1:0] cnt_addr(input int idx);
        return A_CNT_BASE + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int TICK_DIV = 100000,
    localparam int DIV_W   = $clog2(TICK_DIV + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    logic [DIV_W-1:0] pre_q;

    assign tick = run && (pre_q == DIV_W'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tri_timer_pkg::*;
#(
    parameter int        CNT_W = 32,
    parameter tmr_mode_e MODE  = MODE_UP_WRAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step_en,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             evt;
    logic             step;

    assign step = run && step_en;

    // Next value and event flag depend on the fixed mode of this channel.
    generate
        if (MODE == MODE_UP_WRAP) begin : g_wrap
            always_comb begin
                evt = (cnt_q == cmp);
                nxt = evt ? '0 : cnt_q + 1'b1;
            end
        end else if (MODE == MODE_TICK_UP) begin : g_tick
            always_comb begin
                nxt = cnt_q + 1'b1;
                evt = (nxt == cmp);
            end
        end else begin : g_down
            always_comb begin
                evt = (cnt_q == '0);
                nxt = evt ? cmp : cnt_q - 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (ld) begin
                cnt_q <= ld_val;
            end else if (step) begin
                cnt_q <= nxt;
                irq   <= evt;
            end
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_timer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TICK_DIV = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CHAN-1:0] irq
);
    logic [N_CHAN-1:0]             start_q;
    logic [N_CHAN-1:0][CNT_W-1:0]  cmp_q;
    logic [N_CHAN-1:0][CNT_W-1:0]  cnt_w;
    logic [N_CHAN-1:0]             irq_w;
    logic [N_CHAN-1:0]             ld_w;
    logic                          ms_tick;

    // Start byte and compare registers
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cmp_q   <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) begin
                start_q <= bus_wdata[N_CHAN-1:0];
            end
            for (int k = 0; k < N_CHAN; k++) begin
                if (bus_addr == cmp_addr(k)) begin
                    cmp_q[k] <= bus_wdata;
                end
            end
        end
    end

    tmr_prescale #(
        .TICK_DIV (TICK_DIV)
    ) pre_i (
        .clk  (clk),
        .rst  (rst),
        .run  (start_q[1]),
        .tick (ms_tick)
    );

    generate
        for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
            localparam tmr_mode_e CH_MODE = chan_mode(i);
            logic step_src;

            if (CH_MODE == MODE_TICK_UP) begin : g_ms
                assign step_src = ms_tick;
            end else begin : g_clk
                assign step_src = 1'b1;
            end

            assign ld_w[i] = bus_we && (bus_addr == cnt_addr(i));

            tmr_channel #(
                .CNT_W (CNT_W),
                .MODE  (CH_MODE)
            ) chan_i (
                .clk     (clk),
                .rst     (rst),
                .run     (start_q[i]),
                .step_en (step_src),
                .ld      (ld_w[i]),
                .ld_val  (bus_wdata),
                .cmp     (cmp_q[i]),
                .cnt     (cnt_w[i]),
                .irq     (irq_w[i])
            );
        end
    endgenerate

    assign irq = irq_w;

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata = CNT_W'(start_q);
        end else if (bus_addr == A_TICK) begin
            bus_rdata = CNT_W'(TICK_DIV);
        end
        for (int k = 0; k < N_CHAN; k++) begin
            if (bus_addr == cmp_addr(k)) begin
                bus_rdata = cmp_q[k];
            end
            if (bus_addr == cnt_addr(k)) begin
                bus_rdata = cnt_w[k];
            end
        end
    end
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk
    import tri_timer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TICK_DIV = 100000
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         we,
    input logic [ADDR_W-1:0]            addr,
    input logic [CNT_W-1:0]             wdata,
    input logic [CNT_W-1:0]             rdata,
    input logic [N_CHAN-1:0]            irq,
    input logic [N_CHAN-1:0]            start,
    input logic [N_CHAN-1:0][CNT_W-1:0] cnt,
    input logic [N_CHAN-1:0][CNT_W-1:0] cmp,
    input logic                         tick
);
    assert_const_read_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == A_TICK) |-> (rdata == CNT_W'(TICK_DIV)));

    generate
        for (genvar i = 0; i < N_CHAN; i++) begin : g_hold
            assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
                (!start[i] && !(we && addr == cnt_addr(i))) |=> (cnt[i] == $past(cnt[i])));
        end
    endgenerate

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        irq[0] |-> (cnt[0] == '0 && $past(start[0])));

    assert_tick_gated_R5: assert property (@(posedge clk) disable iff (rst)
        tick |-> start[1]);

    assert_match_R6: assert property (@(posedge clk) disable iff (rst)
        irq[1] |-> (cnt[1] == $past(cmp[1])));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        irq[2] |-> (cnt[2] == $past(cmp[2])));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CNT_BASE) |=> (cnt[0] == $past(wdata) && !irq[0]));
endmodule

bind tri_timer tri_timer_chk #(
    .CNT_W    (CNT_W),
    .TICK_DIV (TICK_DIV)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .irq   (irq),
    .start (start_q),
    .cnt   (cnt_w),
    .cmp   (cmp_q),
    .tick  (ms_tick)
);

// File: tb/tri_timer_tb_top.sv
`timescale 1ns/1ps
module tri_timer_tb_top;
    localparam int CW  = 16;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_we;
    logic [2:0]    bus_addr;
    logic [CW-1:0] bus_wdata;
    logic [CW-1:0] bus_rdata;
    logic [2:0]    irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tri_timer #(.CNT_W(CW), .TICK_DIV(DIV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [CW-1:0] v;
        for (int a = 0; a < 8; a++) begin
            if (a != 1) begin
                rd(3'(a), v);
                chk("R1 register zero after reset", 32'(v), 0);
            end
        end
        chk("R1 irq low after reset", 32'(irq), 0);
    endtask

    task automatic t_const;
        logic [CW-1:0] v;
        rd(3'd1, v);
        chk("R2 divisor read", 32'(v), DIV);
        wr(3'd1, 16'd99);
        rd(3'd1, v);
        chk("R2 divisor write ignored", 32'(v), DIV);
    endtask

    task automatic t_timer0;
        logic [CW-1:0] v;
        wr(3'd2, 16'd3);
        wr(3'd0, 16'd1);
        rd(3'd5, v); chk("R3 t0 unchanged at start edge", 32'(v), 0);
        step(3);
        rd(3'd5, v); chk("R4 t0 counts up", 32'(v), 3);
        chk("R4 no irq before match", 32'(irq), 0);
        step(1);
        rd(3'd5, v); chk("R4 t0 wraps to zero", 32'(v), 0);
        chk("R4 irq0 after match", 32'(irq), 1);
        step(1);
        rd(3'd5, v); chk("R4 t0 restarts count", 32'(v), 1);
        chk("R9 irq0 single pulse", 32'(irq), 0);
        wr(3'd0, 16'd0);
        rd(3'd5, v); chk("R3 t0 stepped in stop cycle", 32'(v), 2);
        step(5);
        rd(3'd5, v); chk("R3 t0 holds while stopped", 32'(v), 2);
        wr(3'd0, 16'd1);
        step(1);
        rd(3'd5, v); chk("R3 t0 resumes without reset", 32'(v), 3);
        wr(3'd5, 16'd1);
        rd(3'd5, v); chk("R8 write beats wrap", 32'(v), 1);
        chk("R8 no irq on write cycle", 32'(irq), 0);
        step(1);
        rd(3'd5, v); chk("R8 count resumes from written", 32'(v), 2);
        wr(3'd0, 16'd0);
    endtask

    task automatic t_timer2;
        logic [CW-1:0] v;
        wr(3'd4, 16'd2);
        wr(3'd7, 16'd2);
        wr(3'd0, 16'd4);
        rd(3'd7, v); chk("R7 t2 loaded", 32'(v), 2);
        step(2);
        rd(3'd7, v); chk("R7 t2 counts down", 32'(v), 0);
        chk("R7 no irq at zero yet", 32'(irq), 0);
        step(1);
        rd(3'd7, v); chk("R7 t2 reloads", 32'(v), 2);
        chk("R7 irq2 on reload", 32'(irq), 4);
        step(1);
        rd(3'd7, v); chk("R7 t2 continues", 32'(v), 1);
        chk("R9 irq2 single pulse", 32'(irq), 0);
        wr(3'd0, 16'd0);
    endtask

    task automatic t_timer1;
        logic [CW-1:0] v;
        logic [2:0]    seen;
        wr(3'd3, 16'd2);
        wr(3'd0, 16'd2);
        step(3);
        rd(3'd6, v); chk("R5 no tick before divisor", 32'(v), 0);
        step(1);
        rd(3'd6, v); chk("R5 first tick", 32'(v), 1);
        step(3);
        rd(3'd6, v); chk("R6 t1 waits for tick", 32'(v), 1);
        step(1);
        rd(3'd6, v); chk("R6 t1 reaches compare", 32'(v), 2);
        chk("R6 irq1 on match", 32'(irq), 2);
        seen = '0;
        for (int k = 0; k < 4; k++) begin
            step(1);
            seen = seen | irq;
        end
        rd(3'd6, v); chk("R6 t1 counts past compare", 32'(v), 3);
        chk("R6 no second irq1", 32'(seen), 0);
        step(2);
        wr(3'd0, 16'd0);
        step(2);
        rd(3'd6, v); chk("R3 t1 holds while stopped", 32'(v), 3);
        wr(3'd0, 16'd2);
        step(3);
        rd(3'd6, v); chk("R5 prescaler restarts on start", 32'(v), 3);
        step(1);
        rd(3'd6, v); chk("R5 tick after full period", 32'(v), 4);
        wr(3'd0, 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_const();
        t_timer0();
        t_timer2();
        t_timer1();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule